// File: doc/BRIEF.md
# Synchronous Burst Address Sequencer

This block produces the address stream for a synchronous burst SRAM. On a rising clock edge it can take in an external address through either of two start strobes: one driven from the processor side and one from the memory-controller side. After that it produces the next three addresses of a four-beat burst by itself. A beat moves forward only on a cycle where the advance input is high. The two low address bits follow one of two orders. Linear order counts upward and wraps at four. Interleaved order XORs the captured low bits with a beat counter.

Three chip enables decide whether an accepted strobe starts a burst or deselects the sequencer. The processor-side strobe is also gated by the first enable: while that enable is inactive, the processor-side strobe is ignored. A strobe may arrive on any cycle. It replaces any burst in progress, and it takes precedence over advance.

The controller is a two-state machine. In state `IDLE` the sequencer holds no valid address. In state `BURST` the address output is valid. The transitions are:
- `START`: IDLE or BURST goes to BURST when a strobe is accepted and all enables are active.
- `DESELECT`: IDLE or BURST goes to IDLE when a strobe is accepted and any enable is inactive.
- `STEP`: BURST stays in BURST on advance.
- `WAIT`: the state holds when there is no accepted strobe and no advance.

Top module: `burst_seq`

## Requirements
- R1: During and right after reset, `valid_o` is 0 and `addr_o` is all zeros.
- R2: When `strobe_cpu_i` is high, `en_a_n_i` is 0, `en_b_i` is 1 and `en_c_n_i` is 0 at a rising edge, the next cycle shows `addr_o` equal to the sampled `addr_i` and `valid_o` equal to 1 (beat 0).
- R3: When `strobe_ctl_i` is high with all three enables active (same levels as in R2), the same load happens, whatever the level of `strobe_cpu_i`.
- R4: While `en_a_n_i` is 1, `strobe_cpu_i` has no effect. With `strobe_ctl_i` low, the outputs behave as if no strobe came. With `strobe_ctl_i` high, the outputs behave as for the controller-side strobe alone.
- R5: An accepted strobe while any enable is inactive clears `valid_o` on the next cycle. `addr_o` keeps its previous value.
- R6: In linear order (`order_lin_i` = 1 at load), each advance adds 1 modulo 4 to `addr_o[1:0]` and leaves the upper bits unchanged. Five advances wrap back to the starting address plus one.
- R7: In interleaved order (`order_lin_i` = 0 at load, the default), beat k of a burst shows `addr_o[1:0]` = base[1:0] XOR (k mod 4).
- R8: With `valid_o` high, no accepted strobe and `advance_i` low, `addr_o` and `valid_o` hold.
- R9: A strobe accepted in the middle of a burst restarts at beat 0 of the new address, even when `advance_i` is high in the same cycle.
- R10: The burst order is captured at load. Changing `order_lin_i` during a burst does not change the sequence.
- R11: While `valid_o` is 0, `advance_i` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | External start address |
| strobe_cpu_i | input | 1 | Processor-side start strobe, active high, gated by the first enable |
| strobe_ctl_i | input | 1 | Controller-side start strobe, active high |
| advance_i | input | 1 | Step to the next beat, active high |
| en_a_n_i | input | 1 | First chip enable, active low |
| en_b_i | input | 1 | Second chip enable, active high |
| en_c_n_i | input | 1 | Third chip enable, active low |
| order_lin_i | input | 1 | 1 selects linear order, 0 selects interleaved order |
| addr_o | output | AW | Current burst address |
| valid_o | output | 1 | Address output is valid |

## Verification
The assertions check these rules on every cycle:
- a load shows the sampled address,
- a deselect drops the valid flag,
- advance keeps the upper bits unchanged and, in linear order, adds one to the low bits,
- the address holds when nothing happens,
- an invalid sequencer ignores advance,
- the processor-side strobe is gated by the first enable.

Some behaviours need whole scenarios, and only the bench's sweeps show them: the full interleaved sequence for every base, the wrap after four beats, the priority of a strobe over advance in the same cycle, the capture of the order at load, and all eight enable combinations under each strobe mix.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [0:0] {
        IDLE  = 1'b0,
        BURST = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_seq_arb.sv
module burst_seq_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_cpu_i,
    input  logic strobe_ctl_i,
    input  logic en_a_n_i,
    input  logic en_b_i,
    input  logic en_c_n_i,
    output logic load_o,
    output logic desel_o
);
    logic cpu_ok;
    logic take;
    logic all_on;

    always_comb begin
        cpu_ok  = strobe_cpu_i && !en_a_n_i;
        take    = cpu_ok || strobe_ctl_i;
        all_on  = !en_a_n_i && en_b_i && !en_c_n_i;
        load_o  = take && all_on;
        desel_o = take && !all_on;
    end

    AST_CPU_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n_i && !strobe_ctl_i) |-> !(load_o || desel_o)); // R4

    AST_CTL_DECIDES: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_ctl_i |-> (load_o || desel_o)); // R3
endmodule

// File: rtl/burst_seq_beat.sv
module burst_seq_beat #(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] base_lo_i,
    input  logic [BEAT_W-1:0] count_i,
    input  logic              lin_i,
    output logic [BEAT_W-1:0] lo_o
);
    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    genvar b;
    generate
        for (b = 0; b < BEAT_W; b++) begin : g_ilv
            assign ilv_lo[b] = base_lo_i[b] ^ count_i[b];
        end
    endgenerate

    assign lin_lo = base_lo_i + count_i;
    assign lo_o   = lin_i ? lin_lo : ilv_lo;
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int BEAT_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          strobe_cpu_i,
    input  logic          strobe_ctl_i,
    input  logic          advance_i,
    input  logic          en_a_n_i,
    input  logic          en_b_i,
    input  logic          en_c_n_i,
    input  logic          order_lin_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o
);
    localparam int HI_W = AW - BEAT_W;

    seq_state_t        state_q, state_d;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              lin_q;
    logic              load;
    logic              desel;
    logic [BEAT_W-1:0] lo_addr;

    burst_seq_arb u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_cpu_i (strobe_cpu_i),
        .strobe_ctl_i (strobe_ctl_i),
        .en_a_n_i     (en_a_n_i),
        .en_b_i       (en_b_i),
        .en_c_n_i     (en_c_n_i),
        .load_o       (load),
        .desel_o      (desel)
    );

    burst_seq_beat #(.BEAT_W(BEAT_W)) u_beat (
        .base_lo_i (base_q[BEAT_W-1:0]),
        .count_i   (cnt_q),
        .lin_i     (lin_q),
        .lo_o      (lo_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (load) state_d = BURST;
            BURST:   if (desel) state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            lin_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q <= addr_i;
                cnt_q  <= '0;
                lin_q  <= order_lin_i;
            end else if (!desel && advance_i && state_q == BURST) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        addr_o  = {base_q[AW-1:BEAT_W], lo_addr};
        valid_o = (state_q == BURST);
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_o && addr_o == $past(addr_i))); // R2

    AST_DESEL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (!valid_o && $stable(addr_o))); // R5

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !load && !desel && !advance_i) |=> (valid_o && $stable(addr_o))); // R8

    AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !load && !desel && advance_i)
        |=> (addr_o[AW-1:BEAT_W] == $past(addr_o[AW-1:BEAT_W]))); // R6

    AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && lin_q && !load && !desel && advance_i)
        |=> (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 1'b1)); // R6

    AST_IDLE_ADV: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load) |=> (!valid_o && $stable(addr_o))); // R11

    initial begin
        AST_WIDTH: assert (HI_W > 0); // R6
    end
endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          strobe_cpu_i = 1'b0;
    logic          strobe_ctl_i = 1'b0;
    logic          advance_i = 1'b0;
    logic          en_a_n_i = 1'b1;
    logic          en_b_i = 1'b0;
    logic          en_c_n_i = 1'b1;
    logic          order_lin_i = 1'b0;
    logic [AW-1:0] addr_o;
    logic          valid_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_lin = 1'b0;
    logic          m_valid = 1'b0;

    always #5 clk = ~clk;

    burst_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .strobe_cpu_i(strobe_cpu_i), .strobe_ctl_i(strobe_ctl_i),
        .advance_i(advance_i), .en_a_n_i(en_a_n_i), .en_b_i(en_b_i),
        .en_c_n_i(en_c_n_i), .order_lin_i(order_lin_i),
        .addr_o(addr_o), .valid_o(valid_o)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = m_lin ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic check(input string req);
        logic [AW-1:0] ea;
        ea = exp_addr();
        checks++;
        if (valid_o !== m_valid || addr_o !== ea) begin
            errors++;
            $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
                     req, valid_o, addr_o, m_valid, ea);
        end
    endtask

    task automatic tick(input logic sc, input logic sl, input logic adv,
                        input logic ea_n, input logic eb, input logic ec_n,
                        input logic lin, input logic [AW-1:0] a, input string req);
        logic take, all_on;
        strobe_cpu_i = sc; strobe_ctl_i = sl; advance_i = adv;
        en_a_n_i = ea_n; en_b_i = eb; en_c_n_i = ec_n;
        order_lin_i = lin; addr_i = a;
        take   = (sc && !ea_n) || sl;
        all_on = !ea_n && eb && !ec_n;
        if (take && all_on) begin
            m_base = a; m_cnt = '0; m_lin = lin; m_valid = 1'b1;
        end else if (take) begin
            m_valid = 1'b0;
        end else if (adv && m_valid) begin
            m_cnt = m_cnt + 2'd1;
        end
        @(posedge clk);
        #2;
        check(req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1");
        rst_n = 1'b1;
        #1;
        check("R1");

        // R6 R7 R8 R10: sweep both orders, all four bases, with wrap and holds
        for (int mode = 0; mode < 2; mode++) begin
            for (int b = 0; b < 4; b++) begin
                logic [AW-1:0] a;
                a = AW'(16'h5A40 + b + 4 * mode);
                if (b % 2 == 0) tick(1, 0, 0, 0, 1, 0, mode[0], a, "R2");
                else            tick(0, 1, 0, 0, 1, 0, mode[0], a, "R3");
                for (int k = 0; k < 6; k++) begin
                    tick(0, 0, 1, 0, 1, 0, ~mode[0], '0,
                         mode[0] ? "R6 R10" : "R7 R10");
                    if (k == 2) tick(0, 0, 0, 0, 1, 0, mode[0], '1, "R8");
                end
            end
        end

        // R9: restart mid-burst with advance high in the same cycle
        tick(1, 0, 0, 0, 1, 0, 1, 16'h1233, "R2");
        tick(0, 0, 1, 0, 1, 0, 1, '0, "R6");
        tick(0, 1, 1, 0, 1, 0, 0, 16'hBEE2, "R9");
        tick(0, 0, 1, 0, 1, 0, 1, '0, "R7");
        tick(1, 1, 1, 0, 1, 0, 1, 16'h0F01, "R9 R3");
        tick(0, 0, 1, 0, 1, 0, 0, '0, "R6");

        // R4 R5: all enable combinations under each strobe mix
        for (int s = 1; s < 4; s++) begin
            for (int e = 0; e < 8; e++) begin
                tick(1, 0, 0, 0, 1, 0, 0, 16'h7702, "R2");
                tick(0, 0, 1, 0, 1, 0, 0, '0, "R7");
                tick(s[0], s[1], 1, e[0], e[1], e[2], 1, 16'hC3C1,
                     e[0] ? "R4 R5" : "R5 R2 R3");
                tick(0, 0, 1, 0, 1, 0, 0, '0, "R11 R6");
            end
        end

        // R11: advance while idle
        tick(0, 1, 0, 0, 0, 0, 0, 16'hAAAA, "R5");
        for (int k = 0; k < 4; k++) tick(0, 0, 1, 1, 0, 1, 1, 16'h5555, "R11");
        tick(1, 0, 1, 1, 1, 0, 1, 16'h2222, "R4");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule